// File: doc/BRIEF.md
# Dual-Event Performance Counter with Snapshot Registers

This block counts two streams of single-cycle event pulses. A wide event bus carries one pulse line per event source; each of the two counters picks one line through its own select field and adds one for every pulse seen while counting is enabled. Software starts, stops, zeroes and freezes the counters by writing a command register. The freeze command copies both live counts into a pair of snapshot registers, and every count value read by software comes from those snapshots. A read therefore returns a consistent pair of values whether counting has stopped or is still running.

A count is wider than a data word. The low part of each snapshot is read from a data register of its own. The high part is read from a field of the select register: the full value is the high field shifted left by the low-part width, ORed with the low word. The counts are raw event counts; scaling them to bytes is left to software. A small controller with two states, IDLE and RUN, gates counting. The transition IDLE to RUN happens on a command write with the run bit set, and RUN to IDLE on a command write with the run bit clear. Any other command write keeps the current state.

Top module: `perf_dual_counter`

## Requirements
- R1: After reset every register reads as zero, the controller is in IDLE and both counts are zero.
- R2: Address 1 is the command register. A write with bit 0 set enters RUN and a write with bit 0 clear enters IDLE. Counting follows the state held before the write, so a start takes effect from the cycle after the write. Reading address 1 returns the run state in bit 0 and zero in all other bits.
- R3: Command bit 2 zeroes both live counts at the write edge and drops any event in that cycle. Writing 0x5 zeroes both counts and starts them, and events are counted from the next cycle onward.
- R4: Command bit 1 copies each live count, as it stood before the write edge, into that counter's snapshot. Writing 0x2 takes the snapshot and stops counting in the same write.
- R5: The snapshots change only on a command write with bit 1 set. Reads of the count values stay constant while counting goes on.
- R6: Address 0 holds counter 0's select in bits [6:0] and counter 1's select in bits [14:8]. A counter in RUN adds one in every cycle in which the selected event bit is high. A select write takes effect from the next cycle and leaves both counts unchanged.
- R7: A select code at or above NUM_EVT counts nothing.
- R8: A count stops at all ones. It never wraps.
- R9: Addresses 2 and 3 return the low LOW_W bits of counter 0's and counter 1's snapshots. The upper CNT_W-LOW_W bits appear in address 0 at bits starting at 16 (counter 0) and 24 (counter 1). Writes to those upper fields are ignored.
- R10: Read data is registered: rd_data shows the register at addr one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Single-cycle event pulses, one line per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench builds the block with NUM_EVT=120, CNT_W=8 and LOW_W=4. With these values, select codes 120 to 127 fall outside the event bus, so the path that counts nothing can be tested. Saturation at 255 takes only a few hundred cycles. Each snapshot has a 4-bit high field, and the carry from the low word into it happens after sixteen events. The directed runs hit these corners explicitly, and a seeded random phase mixes commands, select changes and reads while the events keep arriving.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int REG_SEL  = 0;
    localparam int REG_CMD  = 1;
    localparam int REG_LO0  = 2;
    localparam int REG_LO1  = 3;

    localparam int CMD_RUN  = 0;
    localparam int CMD_SNAP = 1;
    localparam int CMD_CLR  = 2;

    localparam int SEL0_LSB = 0;
    localparam int SEL1_LSB = 8;
    localparam int UP0_LSB  = 16;
    localparam int UP1_LSB  = 24;
endpackage

// File: rtl/event_pick.sv
module event_pick #(
    parameter int NUM_EVT = 128,
    parameter int SEL_W   = 7
) (
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               hit_o
);
    localparam int FULL = 1 << SEL_W;

    generate
        if (NUM_EVT == FULL) begin : g_full
            assign hit_o = evt_i[sel_i];
        end else begin : g_padded
            logic [FULL-1:0] ext;
            assign ext   = {{(FULL-NUM_EVT){1'b0}}, evt_i};
            assign hit_o = ext[sel_i];
        end
    endgenerate
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (inc_i && !(&count_o)) begin
            count_o <= count_o + CNT_W'(1);
        end
    end
endmodule

// File: rtl/perf_dual_counter.sv
module perf_dual_counter
    import perfcnt_pkg::*;
#(
    parameter int NUM_EVT = 128,
    parameter int SEL_W   = 7,
    parameter int CNT_W   = 40,
    parameter int LOW_W   = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int NCNT    = 2;
    localparam int UPPER_W = CNT_W - LOW_W;

    run_state_e       state_q, state_d;
    logic             count_en;
    logic             cmd_wr, sel_wr, clear_cmd, snap_cmd;
    logic [SEL_W-1:0] sel_q    [NCNT];
    logic [CNT_W-1:0] cnt_w    [NCNT];
    logic [CNT_W-1:0] shadow_q [NCNT];
    logic [DATA_W-1:0] rd_word;
    logic             unused_wdata;

    assign cmd_wr       = wr_en && (addr == ADDR_W'(REG_CMD));
    assign sel_wr       = wr_en && (addr == ADDR_W'(REG_SEL));
    assign clear_cmd    = cmd_wr && wdata[CMD_CLR];
    assign snap_cmd     = cmd_wr && wdata[CMD_SNAP];
    assign unused_wdata = ^wdata;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_wr && wdata[CMD_RUN])  state_d = ST_RUN;
            ST_RUN:  if (cmd_wr && !wdata[CMD_RUN]) state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        count_en = 1'b0;
        unique case (state_q)
            ST_IDLE: count_en = 1'b0;
            ST_RUN:  count_en = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q[0] <= '0;
            sel_q[1] <= '0;
        end else if (sel_wr) begin
            sel_q[0] <= wdata[SEL0_LSB +: SEL_W];
            sel_q[1] <= wdata[SEL1_LSB +: SEL_W];
        end
    end

    generate
        for (genvar g = 0; g < NCNT; g++) begin : g_cnt
            logic hit;

            event_pick #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_pick (
                .evt_i (evt_i),
                .sel_i (sel_q[g]),
                .hit_o (hit)
            );

            evt_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .clear_i (clear_cmd),
                .inc_i   (count_en && hit),
                .count_o (cnt_w[g])
            );

            always_ff @(posedge clk) begin
                if (!rst_n)        shadow_q[g] <= '0;
                else if (snap_cmd) shadow_q[g] <= cnt_w[g];
            end
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        unique case (addr)
            ADDR_W'(REG_SEL): begin
                rd_word[SEL0_LSB +: SEL_W]  = sel_q[0];
                rd_word[SEL1_LSB +: SEL_W]  = sel_q[1];
                rd_word[UP0_LSB +: UPPER_W] = shadow_q[0][CNT_W-1:LOW_W];
                rd_word[UP1_LSB +: UPPER_W] = shadow_q[1][CNT_W-1:LOW_W];
            end
            ADDR_W'(REG_CMD): rd_word[CMD_RUN]     = (state_q == ST_RUN);
            ADDR_W'(REG_LO0): rd_word[LOW_W-1:0]   = shadow_q[0][LOW_W-1:0];
            ADDR_W'(REG_LO1): rd_word[LOW_W-1:0]   = shadow_q[1][LOW_W-1:0];
            default:          rd_word              = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_word;
    end
endmodule

// File: rtl/perf_dual_counter_chk.sv
module perf_dual_counter_chk #(
    parameter int CNT_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             clear_cmd,
    input logic             snap_cmd,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1,
    input logic [CNT_W-1:0] sh0,
    input logic [CNT_W-1:0] sh1
);
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cmd |=> (cnt0 == '0) && (cnt1 == '0));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !clear_cmd) |=> $stable(cnt0) && $stable(cnt1));

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_cmd |=> (cnt0 >= $past(cnt0)) && (cnt1 >= $past(cnt1)));

    p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_cmd |=> $stable(sh0) && $stable(sh1));

    p_snap_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snap_cmd |=> (sh0 == $past(cnt0)) && (sh1 == $past(cnt1)));
endmodule

bind perf_dual_counter perf_dual_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (count_en),
    .clear_cmd (clear_cmd),
    .snap_cmd  (snap_cmd),
    .cnt0      (cnt_w[0]),
    .cnt1      (cnt_w[1]),
    .sh0       (shadow_q[0]),
    .sh1       (shadow_q[1])
);

// File: tb/tb_perf_dual_counter.sv
module tb_perf_dual_counter;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_EVT = 120;
    localparam int SEL_W   = 7;
    localparam int CNT_W   = 8;
    localparam int LOW_W   = 4;
    localparam int MAXC    = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EVT-1:0] evt = '0;
    logic               wr_en = 1'b0;
    logic [1:0]         addr = '0;
    logic [31:0]        wdata = '0;
    logic [31:0]        rd_data;

    int checks = 0;
    int errors = 0;
    int m_run;
    int m_sel [2];
    int m_cnt [2];
    int m_sh  [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_dual_counter #(
        .NUM_EVT(NUM_EVT), .SEL_W(SEL_W), .CNT_W(CNT_W),
        .LOW_W(LOW_W), .DATA_W(32), .ADDR_W(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data)
    );

    function automatic logic [NUM_EVT-1:0] rnd_evt();
        logic [NUM_EVT-1:0] v;
        for (int i = 0; i < NUM_EVT; i++) v[i] = 1'($urandom & 1);
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        logic [31:0] w;
        w = '0;
        case (a)
            0: begin
                w[6:0]   = 7'(m_sel[0]);
                w[14:8]  = 7'(m_sel[1]);
                w[19:16] = 4'(m_sh[0] >> LOW_W);
                w[27:24] = 4'(m_sh[1] >> LOW_W);
            end
            1: w[0] = 1'(m_run);
            2: w[3:0] = 4'(m_sh[0]);
            default: w[3:0] = 4'(m_sh[1]);
        endcase
        return w;
    endfunction

    task automatic model_update(input logic [NUM_EVT-1:0] ev, input logic we,
                                input logic [1:0] a, input logic [31:0] d);
        int hit [2];
        for (int i = 0; i < 2; i++)
            hit[i] = (m_run != 0 && m_sel[i] < NUM_EVT) ? int'(ev[m_sel[i]]) : 0;
        if (we && a == 2'd1) begin
            if (d[1]) begin m_sh[0] = m_cnt[0]; m_sh[1] = m_cnt[1]; end
            for (int i = 0; i < 2; i++)
                if (d[2]) m_cnt[i] = 0;
                else if (hit[i] != 0 && m_cnt[i] < MAXC) m_cnt[i]++;
            m_run = int'(d[0]);
        end else begin
            for (int i = 0; i < 2; i++)
                if (hit[i] != 0 && m_cnt[i] < MAXC) m_cnt[i]++;
        end
        if (we && a == 2'd0) begin
            m_sel[0] = int'(d[6:0]);
            m_sel[1] = int'(d[14:8]);
        end
    endtask

    task automatic step(input logic [NUM_EVT-1:0] ev, input logic we,
                        input logic [1:0] a, input logic [31:0] d);
        evt = ev; wr_en = we; addr = a; wdata = d;
        @(posedge clk);
        model_update(ev, we, a, d);
        @(negedge clk);
    endtask

    task automatic rd_check(input logic [1:0] a, input string req);
        logic [31:0] e;
        e = exp_read(int'(a));
        step('0, 1'b0, a, '0);
        checks++;
        if (rd_data !== e) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd_data, e);
        end
    endtask

    task automatic run_ones(input int n);
        for (int i = 0; i < n; i++) step('1, 1'b0, 2'd0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20190104));
        m_run = 0;
        for (int i = 0; i < 2; i++) begin m_sel[i] = 0; m_cnt[i] = 0; m_sh[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R10 registered read
        for (int a = 0; a < 4; a++) rd_check(2'(a), "R1");

        // R6 select fields
        step('0, 1'b1, 2'd0, 32'h0000_7705);
        rd_check(2'd0, "R6");

        // R3 clear+start, counting from next cycle
        step('1, 1'b1, 2'd1, 32'h5);
        rd_check(2'd1, "R2");
        run_ones(10);
        // R4 stop+snapshot in one write
        step('1, 1'b1, 2'd1, 32'h2);
        rd_check(2'd2, "R4");
        rd_check(2'd3, "R3");
        rd_check(2'd1, "R2");
        // R2 stopped: no counting while idle
        run_ones(5);
        step('0, 1'b1, 2'd1, 32'h2);
        rd_check(2'd2, "R2");

        // R7 out-of-range select, R9 carry into upper field
        step('0, 1'b1, 2'd0, 32'h0000_7D05);
        step('0, 1'b1, 2'd1, 32'h5);
        run_ones(20);
        step('0, 1'b1, 2'd1, 32'h3);
        rd_check(2'd3, "R7");
        rd_check(2'd2, "R9");
        rd_check(2'd0, "R9");

        // R5 snapshot stays while counting continues
        run_ones(7);
        rd_check(2'd2, "R5");
        rd_check(2'd0, "R5");

        // R9 upper field writes ignored, R6 select write keeps counts
        step('0, 1'b1, 2'd0, 32'hFFFF_0005);
        rd_check(2'd0, "R9");
        step('0, 1'b1, 2'd1, 32'h3);
        rd_check(2'd2, "R6");

        // R8 saturation
        run_ones(300);
        step('1, 1'b1, 2'd1, 32'h2);
        rd_check(2'd2, "R8");
        rd_check(2'd0, "R8");

        // Random phase
        for (int it = 0; it < 1500; it++) begin
            int op;
            op = int'($urandom % 16);
            if (op == 0)      step(rnd_evt(), 1'b1, 2'd1, 32'($urandom % 8));
            else if (op == 1) step(rnd_evt(), 1'b1, 2'd0, $urandom);
            else if (op == 2) rd_check(2'($urandom % 4), "R6");
            else              step(rnd_evt(), 1'b0, 2'd0, '0);
        end
        step('0, 1'b1, 2'd1, 32'h2);
        for (int a = 0; a < 4; a++) rd_check(2'(a), "R4");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule